// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block sits beside a four-channel DMA engine and turns that engine's per-channel event pulses into one level interrupt line per channel. Each channel keeps eight sticky cause flags. Three of them report normal outcomes: transfer done, chain done and chain aborted. Five report faults: configuration fault, chain fault, destination fault, source fault and transfer stall. A per-channel enable register gates the flags. The transfer-done cause has its own enable. Chain done and chain aborted share a second enable. All five fault causes share a third.

The gated causes are reduced to a normal summary and a fault summary for each channel. All eight summaries are shown together in one master status register. A channel's interrupt line is the registered OR of its two summaries. Software reads the cause flags, the enables and the master register over a simple single-cycle register port. It clears cause flags by writing ones to them.

Top module: `dmairq_top`

## Requirements
- R1: After reset, every cause flag, every enable bit and every interrupt line is 0, and the master register reads 0.
- R2: A 1 on evt_i bit (8*c + k) at a rising edge sets cause k of channel c at that edge. The flag stays set until it is cleared by a write. Cause codes: 0 transfer done, 1 chain done, 2 chain aborted, 3 configuration fault, 4 chain fault, 5 destination fault, 6 source fault, 7 transfer stall.
- R3: A write to address c (0..3) clears the cause flags of channel c whose wdata bits are 1. Bits written 0 are left unchanged. A read of address c returns the channel's eight flags.
- R4: If an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: The normal summary of a channel is 1 when cause 0 is set and enable bit 0 (transfer enable) is 1.
- R6: The normal summary is also 1 when cause 1 or cause 2 is set and enable bit 1 (chain enable) is 1.
- R7: The fault summary is 1 when any of causes 3 to 7 is set and enable bit 2 (fault enable) is 1.
- R8: A read of address 8 returns the master register. Bits [3:0] hold the normal summaries of channels 0..3 and bits [7:4] hold the fault summaries.
- R9: irq_o[c] equals the OR of channel c's two summaries as they stood one clock edge earlier.
- R10: Addresses 4..7 hold the enables of channels 0..3. Bits [2:0] are written and read back, and bits [7:3] read as 0.
- R11: Addresses 9..15 read as 0. Writes to them and to address 8 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_i | input | 32 | Event pulses from the DMA engine, 8 per channel |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| irq_o | output | 4 | Level interrupt line per channel |

## Verification
The hardest case to reach from the ports is a clearing write that lands on the same edge as a fresh event for the same flag. The bench drives the write strobe and the event pulse in the same half-cycle, then reads back to confirm the event won and the unpulsed flag was cleared. The one-cycle lag of the interrupt line is also checked. After an event, and again after a clearing write, the bench samples irq_o at two consecutive falling edges and expects the old level first and the new level second.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
    localparam int NCAUSE   = 8;
    localparam int ENW      = 3;
    localparam int C_XFER   = 0;
    localparam int C_CHAIN  = 1;
    localparam int C_ABORT  = 2;
    localparam int C_ERR_LO = 3;
    localparam int E_XFER   = 0;
    localparam int E_CHAIN  = 1;
    localparam int E_ERR    = 2;

    typedef struct packed {
        logic [NCAUSE-1:0] st;
        logic [ENW-1:0]    en;
    } chan_state_t;
endpackage

// File: rtl/dmairq_chan.sv
module dmairq_chan
    import dmairq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCAUSE-1:0] evt_i,
    input  logic              st_wr,
    input  logic              en_wr,
    input  logic [DW-1:0]     wdata,
    output logic [NCAUSE-1:0] st_o,
    output logic [ENW-1:0]    en_o,
    output logic              sum_n_o,
    output logic              sum_e_o
);
    chan_state_t s_d, s_q;
    logic [NCAUSE-1:0] clr_mask;

    always_comb begin
        s_d      = s_q;
        clr_mask = st_wr ? wdata[NCAUSE-1:0] : '0;
        // a new event beats a same-cycle clear
        s_d.st   = (s_q.st & ~clr_mask) | evt_i;
        if (en_wr) begin
            s_d.en = wdata[ENW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign st_o    = s_q.st;
    assign en_o    = s_q.en;
    assign sum_n_o = (s_q.st[C_XFER] & s_q.en[E_XFER])
                   | ((s_q.st[C_CHAIN] | s_q.st[C_ABORT]) & s_q.en[E_CHAIN]);
    assign sum_e_o = (|s_q.st[NCAUSE-1:C_ERR_LO]) & s_q.en[E_ERR];
endmodule

// File: rtl/dmairq_rdmux.sv
module dmairq_rdmux
    import dmairq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 4,
    parameter int DW  = 8
) (
    input  logic [AW-1:0]         addr,
    input  logic [NCH*NCAUSE-1:0] st_flat,
    input  logic [NCH*ENW-1:0]    en_flat,
    input  logic [NCH-1:0]        sum_n,
    input  logic [NCH-1:0]        sum_e,
    output logic [DW-1:0]         rdata
);
    localparam int MST_ADDR = 2 * NCH;

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (addr == AW'(c)) begin
                rdata[NCAUSE-1:0] = st_flat[c*NCAUSE +: NCAUSE];
            end
            if (addr == AW'(NCH + c)) begin
                rdata[ENW-1:0] = en_flat[c*ENW +: ENW];
            end
        end
        if (addr == AW'(MST_ADDR)) begin
            rdata[NCH-1:0]     = sum_n;
            rdata[2*NCH-1:NCH] = sum_e;
        end
    end
endmodule

// File: rtl/dmairq_top.sv
module dmairq_top
    import dmairq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 4,
    parameter int DW  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH*NCAUSE-1:0] evt_i,
    input  logic                  wr_en,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    output logic [NCH-1:0]        irq_o
);
    logic [NCH*NCAUSE-1:0] st_flat;
    logic [NCH*ENW-1:0]    en_flat;
    logic [NCH-1:0]        sum_n, sum_e;
    logic [NCH-1:0]        irq_d, irq_q;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic st_wr, en_wr;
        assign st_wr = wr_en && (addr == AW'(c));
        assign en_wr = wr_en && (addr == AW'(NCH + c));

        dmairq_chan #(.DW(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt_i[c*NCAUSE +: NCAUSE]),
            .st_wr   (st_wr),
            .en_wr   (en_wr),
            .wdata   (wdata),
            .st_o    (st_flat[c*NCAUSE +: NCAUSE]),
            .en_o    (en_flat[c*ENW +: ENW]),
            .sum_n_o (sum_n[c]),
            .sum_e_o (sum_e[c])
        );
    end

    dmairq_rdmux #(.NCH(NCH), .AW(AW), .DW(DW)) u_rdmux (
        .addr    (addr),
        .st_flat (st_flat),
        .en_flat (en_flat),
        .sum_n   (sum_n),
        .sum_e   (sum_e),
        .rdata   (rdata)
    );

    always_comb begin
        irq_d = sum_n | sum_e;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/dmairq_checker.sv
module dmairq_checker
    import dmairq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 4,
    parameter int DW  = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NCH*NCAUSE-1:0] evt_i,
    input logic                  wr_en,
    input logic [AW-1:0]         addr,
    input logic [DW-1:0]         wdata,
    input logic [NCH-1:0]        irq_o,
    input logic [NCH*NCAUSE-1:0] st_flat,
    input logic [NCH-1:0]        sum_n,
    input logic [NCH-1:0]        sum_e
);
    logic [NCH*NCAUSE-1:0] clr_req;

    always_comb begin
        clr_req = '0;
        for (int c = 0; c < NCH; c++) begin
            if (wr_en && addr == AW'(c)) begin
                clr_req[c*NCAUSE +: NCAUSE] = wdata[NCAUSE-1:0];
            end
        end
    end

    // R2 and R4: every pulsed cause is set after the edge, cleared or not
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_flat & $past(evt_i)) == $past(evt_i)));

    // R3: a flag falls only where a clearing write asked for it
    assert_sticky_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~st_flat & $past(st_flat) & ~$past(clr_req)) == '0));

    // R9: the line follows the summaries one edge later
    assert_irq_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(sum_n | sum_e)));

    for (genvar c = 0; c < NCH; c++) begin : g_sum
        assert_norm_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
            sum_n[c] |-> (|st_flat[c*NCAUSE +: C_ERR_LO]));
        assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
            sum_e[c] |-> (|st_flat[c*NCAUSE+C_ERR_LO +: NCAUSE-C_ERR_LO]));
    end
endmodule

bind dmairq_top dmairq_checker #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .irq_o   (irq_o),
    .st_flat (st_flat),
    .sum_n   (sum_n),
    .sum_e   (sum_e)
);

// File: tb/dmairq_top_test.sv
module dmairq_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int AW  = 4;
    localparam int DW  = 8;
    localparam int NV  = 9;

    // {channel[1:0], event mask[7:0], enable[2:0], normal, fault}
    localparam logic [14:0] VEC [NV] = '{
        {2'd0, 8'h01, 3'b001, 1'b1, 1'b0},
        {2'd1, 8'h01, 3'b000, 1'b0, 1'b0},
        {2'd2, 8'h02, 3'b010, 1'b1, 1'b0},
        {2'd3, 8'h04, 3'b010, 1'b1, 1'b0},
        {2'd0, 8'h04, 3'b001, 1'b0, 1'b0},
        {2'd1, 8'h80, 3'b100, 1'b0, 1'b1},
        {2'd2, 8'h08, 3'b011, 1'b0, 1'b0},
        {2'd3, 8'h30, 3'b111, 1'b0, 1'b1},
        {2'd1, 8'h41, 3'b101, 1'b1, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   evt_i = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [NCH-1:0] irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    dmairq_top #(.NCH(NCH), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        addr = AW'(a);
        #1 d = rdata;
    endtask

    task automatic pulse(input int c, input logic [7:0] m);
        @(negedge clk);
        evt_i[c*8 +: 8] = m;
        @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 32'(irq_o), 0);
        rd(0, d); check("R1 status", 32'(d), 0);
        rd(4, d); check("R1 enable", 32'(d), 0);
        rd(8, d); check("R1 master", 32'(d), 0);

        // vector table: R5 R6 R7 R8 R9 R2
        for (int i = 0; i < NV; i++) begin
            int c;
            logic [7:0] m;
            logic [2:0] en;
            logic n, e;
            c  = int'(VEC[i][14:13]);
            m  = VEC[i][12:5];
            en = VEC[i][4:2];
            n  = VEC[i][1];
            e  = VEC[i][0];
            wr(NCH + c, {5'b0, en});
            pulse(c, m);
            @(negedge clk);
            check("R9 R5 R6 R7 irq", 32'(irq_o), 32'((n | e) << c));
            rd(8, d);
            check("R8 master", 32'(d), 32'((n << c) | (e << (4 + c))));
            rd(c, d);
            check("R2 status", 32'(d), 32'(m));
            wr(c, 8'hFF);
            wr(NCH + c, 8'h00);
            @(negedge clk);
        end

        // R3 partial clear, zeros leave flags alone
        pulse(0, 8'h0F);
        wr(0, 8'h05);
        rd(0, d); check("R3 partial clear", 32'(d), 32'h0A);
        wr(0, 8'h00);
        rd(0, d); check("R3 zero write", 32'(d), 32'h0A);
        wr(0, 8'hFF);
        rd(0, d); check("R3 full clear", 32'(d), 0);

        // R4 clear and set on the same edge
        pulse(1, 8'h03);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(1); wdata = 8'h03; evt_i[8 +: 8] = 8'h01;
        @(negedge clk);
        wr_en = 1'b0; evt_i = '0;
        rd(1, d); check("R4 set wins", 32'(d), 32'h01);
        wr(1, 8'hFF);

        // R9 lag on rise and fall
        wr(6, 8'h04);
        pulse(2, 8'h80);
        check("R9 before rise", 32'(irq_o[2]), 0);
        @(negedge clk);
        check("R9 after rise", 32'(irq_o[2]), 1);
        wr(2, 8'h80);
        check("R9 before fall", 32'(irq_o[2]), 1);
        @(negedge clk);
        check("R9 after fall", 32'(irq_o[2]), 0);
        wr(6, 8'h00);

        // R10 enable width
        wr(7, 8'hFF);
        rd(7, d); check("R10 enable readback", 32'(d), 32'h07);
        wr(7, 8'h00);

        // R11 unmapped and master writes ignored
        wr(9, 8'hFF);
        wr(8, 8'hFF);
        rd(9, d);  check("R11 addr 9", 32'(d), 0);
        rd(15, d); check("R11 addr 15", 32'(d), 0);
        rd(8, d);  check("R11 master untouched", 32'(d), 0);
        rd(4, d);  check("R11 enable untouched", 32'(d), 0);
        rd(0, d);  check("R11 status untouched", 32'(d), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule